// File: doc/BRIEF.md
# Access-Permission Cache with Selective Fence Invalidation

This block is a small, fully associative cache of memory access permissions. It is indexed by physical address and by supervisor-domain identifier. Each entry records a region base address, the granularity of that region, the owning domain and three permission bits. A lookup gives a hit flag and the stored permissions in the same cycle. When the lookup misses, the block asks for a fill. The table walk that answers that request lies outside this block, and it returns the entry on the fill inputs.

The block also carries out the machine-mode physical-address fence. A fence request brings an address, a domain identifier, one flag per operand that says the operand is the zero register, and the requester's privilege level. The address and the domain each narrow the invalidation independently of the other. The address test uses only the bits that lie above each entry's own region size. Every matching entry is cleared in a single cycle, and a completion pulse follows one cycle later.

Top module: `perm_fence_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `fence_done` and `fence_illegal` are low.
- R2: A lookup hits when a valid entry has an equal domain and a region that covers the address. It returns `lkp_perm` = {read, write, execute} (bit 2 = read, bit 0 = execute) in the same cycle. A miss drives `lkp_perm` to 0 and raises `lkp_fill_req`.
- R3: An installed fill goes to the slot named by a round-robin pointer, which starts at 0 after reset and wraps after slot 7. The entry can be looked up from the next cycle on, and a ninth fill evicts the first.
- R4: A fence request with `fence_priv` other than 2'b11 (machine) pulses `fence_illegal` one cycle later, does not pulse `fence_done`, and leaves every entry valid.
- R5: An accepted fence with both zero flags set invalidates every entry of every domain. Any accepted fence pulses `fence_done` high for exactly the next cycle.
- R6: When only the domain operand is non-zero (`fence_rs1_zero`=1, `fence_rs2_zero`=0), the fence invalidates exactly the entries whose domain equals `fence_did`. Their addresses do not matter.
- R7: When only the address operand is non-zero, the fence invalidates the entries of any domain whose region covers `fence_pa`.
- R8: When both operands are non-zero, the fence invalidates only the entries that both cover `fence_pa` and carry `fence_did`.
- R9: Region coverage depends on the granularity code. 0 = 4 KiB, which compares PA bits 12 and up. 1 = 2 MiB, which compares bits 21 and up. 2 = 4 MiB, which compares bits 22 and up. 3 = 1 GiB, which compares bits 30 and up.
- R10: A lookup made in the same cycle as an accepted fence sees the entries after the invalidation.
- R11: A fill that arrives in the same cycle as an accepted fence is discarded if the fence would invalidate that fill's entry, and the pointer does not advance. A fill that the fence does not match is installed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_pa | input | PA_W | Lookup physical address |
| lkp_did | input | DID_W | Lookup domain identifier |
| lkp_hit | output | 1 | Lookup hit |
| lkp_perm | output | 3 | Permissions of the hit entry {r,w,x} |
| lkp_fill_req | output | 1 | Lookup missed; fill wanted |
| fill_valid | input | 1 | Fill entry present |
| fill_pa | input | PA_W | Fill region base address |
| fill_did | input | DID_W | Fill domain identifier |
| fill_gran | input | 2 | Fill granularity code |
| fill_perm | input | 3 | Fill permissions {r,w,x} |
| fence_req | input | 1 | Fence request |
| fence_priv | input | 2 | Requester privilege level |
| fence_rs1_zero | input | 1 | Address operand is the zero register |
| fence_rs2_zero | input | 1 | Domain operand is the zero register |
| fence_pa | input | PA_W | Fence physical address |
| fence_did | input | DID_W | Fence domain identifier |
| fence_done | output | 1 | Fence completion pulse |
| fence_illegal | output | 1 | Fence refused for privilege |

## Verification
Three activities can fall in the same cycle as a fence: a lookup, a fill, or both. The bench drives a domain-qualified fence while a lookup is active. It then reads the hit flag before the clock edge, and a killed entry must already miss while an untouched one still hits. It also applies a fill together with a fence, once with a fill the fence matches and once with one it does not. The outcome is judged through later lookups, which show whether the entry was installed and which slot the round-robin pointer overwrote.

// File: rtl/perm_fence_pkg.sv
`timescale 1ns/1ps
package perm_fence_pkg;

    typedef enum logic [1:0] {
        GRAN_4K = 2'd0,
        GRAN_2M = 2'd1,
        GRAN_4M = 2'd2,
        GRAN_1G = 2'd3
    } gran_e;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam int unsigned PERM_W = 3;

    // lowest address bit that still takes part in a region compare
    function automatic int unsigned gran_lsb(gran_e g);
        case (g)
            GRAN_4K: return 12;
            GRAN_2M: return 21;
            GRAN_4M: return 22;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/pc_fence_decode.sv
`timescale 1ns/1ps
module pc_fence_decode
    import perm_fence_pkg::*;
(
    input  logic       req,
    input  logic [1:0] priv,
    input  logic       rs1_zero,
    input  logic       rs2_zero,
    output logic       accept,
    output logic       illegal,
    output logic       by_addr,
    output logic       by_did
);
    always_comb begin
        accept  = req && (priv == PRIV_MACHINE);
        illegal = req && (priv != PRIV_MACHINE);
        by_addr = !rs1_zero;
        by_did  = !rs2_zero;
    end
endmodule

// File: rtl/pc_region_match.sv
`timescale 1ns/1ps
module pc_region_match
    import perm_fence_pkg::*;
#(
    parameter int unsigned PA_W = 34
) (
    input  logic [PA_W-1:0] base_pa,
    input  gran_e           gran,
    input  logic [PA_W-1:0] probe_pa,
    output logic            covers
);
    logic [PA_W-1:0] diff;
    always_comb begin
        diff   = (base_pa ^ probe_pa) >> gran_lsb(gran);
        covers = (diff == '0);
    end
endmodule

// File: rtl/pc_entry_cmp.sv
`timescale 1ns/1ps
module pc_entry_cmp
    import perm_fence_pkg::*;
#(
    parameter int unsigned PA_W  = 34,
    parameter int unsigned DID_W = 6
) (
    input  logic             ent_valid,
    input  logic [PA_W-1:0]  ent_pa,
    input  logic [DID_W-1:0] ent_did,
    input  gran_e            ent_gran,
    input  logic             fence_accept,
    input  logic             by_addr,
    input  logic             by_did,
    input  logic [PA_W-1:0]  fence_pa,
    input  logic [DID_W-1:0] fence_did,
    input  logic [PA_W-1:0]  lkp_pa,
    input  logic [DID_W-1:0] lkp_did,
    output logic             kill,
    output logic             lkp_match
);
    logic fence_cov;
    logic lkp_cov;

    pc_region_match #(.PA_W(PA_W)) i_fence_rm (
        .base_pa (ent_pa),
        .gran    (ent_gran),
        .probe_pa(fence_pa),
        .covers  (fence_cov)
    );

    pc_region_match #(.PA_W(PA_W)) i_lkp_rm (
        .base_pa (ent_pa),
        .gran    (ent_gran),
        .probe_pa(lkp_pa),
        .covers  (lkp_cov)
    );

    always_comb begin
        kill = fence_accept && ent_valid
            && (!by_did  || (ent_did == fence_did))
            && (!by_addr || fence_cov);
        // the lookup sees the table as it stands after this cycle's sweep
        lkp_match = ent_valid && !kill && (ent_did == lkp_did) && lkp_cov;
    end
endmodule

// File: rtl/perm_fence_cache.sv
`timescale 1ns/1ps
module perm_fence_cache
    import perm_fence_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned PA_W        = 34,
    parameter int unsigned DID_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [PA_W-1:0]   lkp_pa,
    input  logic [DID_W-1:0]  lkp_did,
    output logic              lkp_hit,
    output logic [PERM_W-1:0] lkp_perm,
    output logic              lkp_fill_req,
    input  logic              fill_valid,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [DID_W-1:0]  fill_did,
    input  logic [1:0]        fill_gran,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fence_req,
    input  logic [1:0]        fence_priv,
    input  logic              fence_rs1_zero,
    input  logic              fence_rs2_zero,
    input  logic [PA_W-1:0]   fence_pa,
    input  logic [DID_W-1:0]  fence_did,
    output logic              fence_done,
    output logic              fence_illegal
);
    localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    typedef struct packed {
        logic [NUM_ENTRIES-1:0]                   valid;
        logic [NUM_ENTRIES-1:0][PA_W-1:0]         pa;
        logic [NUM_ENTRIES-1:0][DID_W-1:0]        did;
        logic [NUM_ENTRIES-1:0][1:0]              gran;
        logic [NUM_ENTRIES-1:0][PERM_W-1:0]       perm;
        logic [IDX_W-1:0]                         rr;
        logic                                     done;
        logic                                     illegal;
    } state_t;

    state_t state_d, state_q;

    logic fence_accept, fence_bad, by_addr, by_did;
    logic [NUM_ENTRIES-1:0] kill_vec;
    logic [NUM_ENTRIES-1:0] match_vec;
    logic fill_cov, fill_stale, fill_install;

    pc_fence_decode i_dec (
        .req     (fence_req),
        .priv    (fence_priv),
        .rs1_zero(fence_rs1_zero),
        .rs2_zero(fence_rs2_zero),
        .accept  (fence_accept),
        .illegal (fence_bad),
        .by_addr (by_addr),
        .by_did  (by_did)
    );

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
            pc_entry_cmp #(.PA_W(PA_W), .DID_W(DID_W)) i_cmp (
                .ent_valid   (state_q.valid[g]),
                .ent_pa      (state_q.pa[g]),
                .ent_did     (state_q.did[g]),
                .ent_gran    (gran_e'(state_q.gran[g])),
                .fence_accept(fence_accept),
                .by_addr     (by_addr),
                .by_did      (by_did),
                .fence_pa    (fence_pa),
                .fence_did   (fence_did),
                .lkp_pa      (lkp_pa),
                .lkp_did     (lkp_did),
                .kill        (kill_vec[g]),
                .lkp_match   (match_vec[g])
            );
        end
    endgenerate

    // a fill that the concurrent fence would remove is stale and dropped
    pc_region_match #(.PA_W(PA_W)) i_fill_rm (
        .base_pa (fill_pa),
        .gran    (gran_e'(fill_gran)),
        .probe_pa(fence_pa),
        .covers  (fill_cov)
    );

    always_comb begin
        fill_stale = fence_accept
            && (!by_did  || (fill_did == fence_did))
            && (!by_addr || fill_cov);
        fill_install = fill_valid && !fill_stale;
    end

    // lookup: lowest matching slot wins
    always_comb begin
        logic             found;
        logic [PERM_W-1:0] sel;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!found && match_vec[i]) begin
                found = 1'b1;
                sel   = state_q.perm[i];
            end
        end
        lkp_hit      = lkp_valid && found;
        lkp_perm     = (lkp_valid && found) ? sel : '0;
        lkp_fill_req = lkp_valid && !found;
    end

    always_comb begin
        state_d         = state_q;
        state_d.done    = fence_accept;
        state_d.illegal = fence_bad;
        state_d.valid   = state_q.valid & ~kill_vec;
        if (fill_install) begin
            state_d.valid[state_q.rr] = 1'b1;
            state_d.pa[state_q.rr]    = fill_pa;
            state_d.did[state_q.rr]   = fill_did;
            state_d.gran[state_q.rr]  = fill_gran;
            state_d.perm[state_q.rr]  = fill_perm;
            state_d.rr = (state_q.rr == LAST_IDX) ? '0 : state_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign fence_done    = state_q.done;
    assign fence_illegal = state_q.illegal;

    p_done_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && fence_priv == PRIV_MACHINE) |=> (fence_done && !fence_illegal));

    p_low_priv_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && fence_priv != PRIV_MACHINE && !fill_valid)
        |=> (fence_illegal && !fence_done && state_q.valid == $past(state_q.valid)));

    p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && fence_priv == PRIV_MACHINE && fence_rs1_zero && fence_rs2_zero
         && !fill_valid) |=> (state_q.valid == '0));

    p_rr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_install |=> (state_q.rr == (($past(state_q.rr) == LAST_IDX) ? '0
                                          : $past(state_q.rr) + 1'b1)));

    p_stale_fill_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_stale) |=> $stable(state_q.rr));

    p_hit_or_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |-> $countones({lkp_hit, lkp_fill_req}) == 1);

endmodule

// File: tb/test_perm_fence_cache.sv
`timescale 1ns/1ps
module test_perm_fence_cache;
    localparam int PA_W = 34;
    localparam int DID_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lkp_valid = 1'b0;
    logic [PA_W-1:0] lkp_pa = '0;
    logic [DID_W-1:0] lkp_did = '0;
    logic lkp_hit, lkp_fill_req;
    logic [2:0] lkp_perm;
    logic fill_valid = 1'b0;
    logic [PA_W-1:0] fill_pa = '0;
    logic [DID_W-1:0] fill_did = '0;
    logic [1:0] fill_gran = '0;
    logic [2:0] fill_perm = '0;
    logic fence_req = 1'b0;
    logic [1:0] fence_priv = 2'b11;
    logic fence_rs1_zero = 1'b1, fence_rs2_zero = 1'b1;
    logic [PA_W-1:0] fence_pa = '0;
    logic [DID_W-1:0] fence_did = '0;
    logic fence_done, fence_illegal;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    perm_fence_cache i_perm_fence_cache (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_pa(lkp_pa), .lkp_did(lkp_did),
        .lkp_hit(lkp_hit), .lkp_perm(lkp_perm), .lkp_fill_req(lkp_fill_req),
        .fill_valid(fill_valid), .fill_pa(fill_pa), .fill_did(fill_did),
        .fill_gran(fill_gran), .fill_perm(fill_perm),
        .fence_req(fence_req), .fence_priv(fence_priv),
        .fence_rs1_zero(fence_rs1_zero), .fence_rs2_zero(fence_rs2_zero),
        .fence_pa(fence_pa), .fence_did(fence_did),
        .fence_done(fence_done), .fence_illegal(fence_illegal)
    );

    // preload set: 4K, 4K, 2M, 4M, 1G, 1G, 4K, 4K
    localparam logic [PA_W-1:0] PRE_PA [8] = '{
        34'h0_0000_1000, 34'h0_0000_2000, 34'h0_0020_0000, 34'h0_0040_0000,
        34'h0_4000_0000, 34'h0_8000_0000, 34'h1_0000_3000, 34'h0_0000_1000};
    localparam logic [DID_W-1:0] PRE_DID [8] = '{1, 2, 1, 3, 1, 2, 3, 2};
    localparam logic [1:0] PRE_GRAN [8] = '{0, 0, 1, 2, 3, 3, 0, 0};
    localparam logic [2:0] PRE_PERM [8] = '{3'b100, 3'b110, 3'b101, 3'b111,
                                            3'b001, 3'b010, 3'b011, 3'b100};

    // {rs1_zero, rs2_zero, pa[33:0], did[5:0], surviving-entry mask}
    localparam logic [49:0] FV [12] = '{
        {1'b1, 1'b1, 34'h0_0000_1000, 6'd1, 8'h00},   // R5
        {1'b1, 1'b0, 34'h0_4000_0000, 6'd1, 8'hEA},   // R6
        {1'b1, 1'b0, 34'h0_0000_0000, 6'd2, 8'h5D},   // R6
        {1'b0, 1'b1, 34'h0_0000_1ABC, 6'd5, 8'h7E},   // R7 4K
        {1'b0, 1'b1, 34'h0_0030_0000, 6'd0, 8'hFB},   // R9 2M
        {1'b0, 1'b1, 34'h0_0041_2345, 6'd0, 8'hF7},   // R9 4M
        {1'b0, 1'b1, 34'h0_5234_5678, 6'd0, 8'hEF},   // R9 1G
        {1'b0, 1'b0, 34'h0_0000_1000, 6'd2, 8'h7F},   // R8
        {1'b0, 1'b0, 34'h0_4000_0000, 6'd2, 8'hFF},   // R8 domain mismatch
        {1'b0, 1'b0, 34'h1_0000_3FFF, 6'd3, 8'hBF},   // R8 top of page
        {1'b0, 1'b1, 34'h0_001F_FFFF, 6'd0, 8'hFF},   // R9 just below 2M base
        {1'b0, 1'b1, 34'h0_7FFF_FFFF, 6'd0, 8'hEF}    // R9 top of 1G
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill_one(input logic [PA_W-1:0] pa, input logic [DID_W-1:0] did,
                            input logic [1:0] gr, input logic [2:0] pm);
        @(negedge clk);
        fill_valid = 1'b1; fill_pa = pa; fill_did = did; fill_gran = gr; fill_perm = pm;
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic preload();
        do_reset();
        for (int i = 0; i < 8; i++) fill_one(PRE_PA[i], PRE_DID[i], PRE_GRAN[i], PRE_PERM[i]);
    endtask

    task automatic set_fence(input bit r1z, input bit r2z, input logic [PA_W-1:0] pa,
                             input logic [DID_W-1:0] did, input logic [1:0] pv);
        fence_req = 1'b1; fence_rs1_zero = r1z; fence_rs2_zero = r2z;
        fence_pa = pa; fence_did = did; fence_priv = pv;
    endtask

    task automatic lookup_check(input logic [PA_W-1:0] pa, input logic [DID_W-1:0] did,
                                input bit exp_hit, input logic [2:0] exp_perm, input string req);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_pa = pa; lkp_did = did;
        #1;
        check(lkp_hit == exp_hit, req, lkp_hit, exp_hit);
        check(lkp_perm == exp_perm, req, lkp_perm, exp_perm);
        check(lkp_fill_req == !exp_hit, req, lkp_fill_req, !exp_hit);
        lkp_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        check(fence_done == 1'b0, "R1", fence_done, 0);
        check(fence_illegal == 1'b0, "R1", fence_illegal, 0);
        lookup_check(34'h0_0000_1000, 6'd1, 1'b0, 3'b000, "R1");

        // R2: all preloaded entries hit with their own permissions
        preload();
        for (int i = 0; i < 8; i++) lookup_check(PRE_PA[i], PRE_DID[i], 1'b1, PRE_PERM[i], "R2");
        lookup_check(34'h0_0000_1000, 6'd4, 1'b0, 3'b000, "R2");

        // R5..R9: fence vector table
        for (int v = 0; v < 12; v++) begin
            preload();
            @(negedge clk);
            set_fence(FV[v][49], FV[v][48], FV[v][47:14], FV[v][13:8], 2'b11);
            @(posedge clk);
            #1 fence_req = 1'b0;
            check(fence_done == 1'b1, "R5", fence_done, 1);
            check(fence_illegal == 1'b0, "R5", fence_illegal, 0);
            for (int i = 0; i < 8; i++)
                lookup_check(PRE_PA[i], PRE_DID[i], FV[v][i],
                             FV[v][i] ? PRE_PERM[i] : 3'b000, "R6_R7_R8_R9");
        end
        // R5: done lasts one cycle
        #1 check(fence_done == 1'b0, "R5", fence_done, 0);

        // R4: supervisor-level fence is refused
        preload();
        @(negedge clk);
        set_fence(1'b1, 1'b1, '0, '0, 2'b01);
        @(posedge clk);
        #1 fence_req = 1'b0; fence_priv = 2'b11;
        check(fence_illegal == 1'b1, "R4", fence_illegal, 1);
        check(fence_done == 1'b0, "R4", fence_done, 0);
        for (int i = 0; i < 8; i++) lookup_check(PRE_PA[i], PRE_DID[i], 1'b1, PRE_PERM[i], "R4");

        // R10: lookup during the fence cycle sees post-sweep table
        preload();
        @(negedge clk);
        set_fence(1'b1, 1'b0, '0, 6'd1, 2'b11);
        lkp_valid = 1'b1; lkp_pa = PRE_PA[0]; lkp_did = PRE_DID[0];
        #1;
        check(lkp_hit == 1'b0, "R10", lkp_hit, 0);
        check(lkp_fill_req == 1'b1, "R10", lkp_fill_req, 1);
        lkp_pa = PRE_PA[1]; lkp_did = PRE_DID[1];
        #0.5;
        check(lkp_hit == 1'b1, "R10", lkp_hit, 1);
        @(posedge clk);
        #1 fence_req = 1'b0; lkp_valid = 1'b0;

        // R3: ninth fill evicts slot 0
        preload();
        fill_one(34'h0_0000_9000, 6'd5, 2'd0, 3'b111);
        lookup_check(PRE_PA[0], PRE_DID[0], 1'b0, 3'b000, "R3");
        lookup_check(PRE_PA[1], PRE_DID[1], 1'b1, PRE_PERM[1], "R3");
        lookup_check(34'h0_0000_9000, 6'd5, 1'b1, 3'b111, "R3");

        // R11: fill matched by concurrent fence is dropped, pointer holds
        preload();
        @(negedge clk);
        set_fence(1'b1, 1'b0, '0, 6'd1, 2'b11);
        fill_valid = 1'b1; fill_pa = 34'h0_0000_5000; fill_did = 6'd1;
        fill_gran = 2'd0; fill_perm = 3'b110;
        @(posedge clk);
        #1 fence_req = 1'b0; fill_valid = 1'b0;
        lookup_check(34'h0_0000_5000, 6'd1, 1'b0, 3'b000, "R11");
        fill_one(34'h0_0000_6000, 6'd4, 2'd0, 3'b010);   // goes to slot 0
        lookup_check(PRE_PA[1], PRE_DID[1], 1'b1, PRE_PERM[1], "R11");
        lookup_check(34'h0_0000_6000, 6'd4, 1'b1, 3'b010, "R11");
        // unmatched fill with fence: installed in slot 1
        @(negedge clk);
        set_fence(1'b1, 1'b0, '0, 6'd1, 2'b11);
        fill_valid = 1'b1; fill_pa = 34'h0_0000_7000; fill_did = 6'd4;
        fill_gran = 2'd0; fill_perm = 3'b001;
        @(posedge clk);
        #1 fence_req = 1'b0; fill_valid = 1'b0;
        lookup_check(34'h0_0000_7000, 6'd4, 1'b1, 3'b001, "R11");
        lookup_check(PRE_PA[1], PRE_DID[1], 1'b0, 3'b000, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule